// File: doc/BRIEF.md
# Two-wire setting register controller

This block is a slave on a two-wire serial bus (I2C/SMBus style). It holds one 8-bit setting byte. The five high bits of the byte form a DAC code and the three low bits set three general-purpose logic outputs. The controller runs on a fast system clock and oversamples the clock and data lines. Each line passes through a synchronizer and a glitch filter before START, STOP and clock edges are found.

Every transfer is a fixed three-byte frame. A write sends the address byte with the direction bit clear, then the command byte AAh, then the new setting. A read sends the address byte with the direction bit set. The slave then returns a constant marker byte 00h, followed by the current setting. The slave drives the data line only by pulling it low, through an enable output. The board supplies the pull-up.

Top module: `tw_setting_ctrl`

## Requirements
- R1: After reset the setting byte is 00h, so `dac_code_o` = 0 and `pin_o` = 0, and `sda_pull_o` is 0 (data line released).
- R2: A write frame ACKs all three bytes and loads the setting byte. The frame is START, byte 58h (address 0101100 in bits 7:1, direction bit 0 = write), byte AAh, data byte, STOP, with every byte MSB first. An ACK means the slave holds SDA low during the 9th clock. Afterwards `dac_code_o` = data[7:3], passed on unchanged; the code 11111 requests the lowest analog level and 00000 the highest. `pin_o[2:0]` = data[2:0], and a 1 drives that pin high.
- R3: A read frame with address byte 59h (direction bit 1) is ACKed. The slave then sends 00h and, after the master ACKs that byte, the setting byte, MSB first in both cases.
- R4: If bits 7:1 of the address byte differ from 0101100, the slave does not ACK. It pulls SDA for none of the following bytes until the next STOP or START, and the setting byte is unchanged.
- R5: In a write frame whose second byte is not AAh, that byte is NACKed, the data byte that follows is not ACKed, and the setting byte is unchanged.
- R6: A START seen before a frame completes abandons the frame and leaves the setting byte unchanged. The new START begins a fresh frame that is handled normally.
- R7: A pulse shorter than FILT_LEN system clocks on SCL or SDA is ignored. It adds no bit and forms no START or STOP.
- R8: If the master NACKs the marker byte of a read, the slave sends no setting byte. It releases SDA until the next STOP or START.
- R9: The setting byte changes only after the falling SCL edge that ends the ACK clock of the data byte. During that ACK clock the outputs still show the old value.
- R10: The slave changes `sda_pull_o` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |
| dac_code_o | output | DAC_W | Setting bits 7:3, DAC code |
| pin_o | output | 8-DAC_W | Setting bits 2:0, output pin levels |

## Verification
The bench uses the default parameters: a two-flop synchronizer, a three-clock filter, address 2Ch, command AAh, marker 00h and a 5/3 split of the byte. It runs SCL at one fortieth of the system clock. That ratio leaves about ten clocks of filter and register latency inside each SCL phase, so the slave's ACK and read bits settle well before the next rising edge. With the filter length of three, two-clock glitches fall just short of the threshold. This exercises the boundary of the filter on both lines.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_OUT,
    ST_TX,
    ST_ACK_IN,
    ST_DONE
  } tw_state_e;
endpackage

// File: rtl/tw_line_filter.sv
module tw_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN = 3,
  parameter logic RESET_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic sync_last;

  assign sync_last = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= {SYNC_STAGES{RESET_LVL}};
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end
  end

  // The output follows only after FILT_LEN consecutive differing samples.
  always_ff @(posedge clk) begin
    if (rst) begin
      line_o <= RESET_LVL;
      cnt_q  <= '0;
    end else if (sync_last != line_o) begin
      if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
        line_o <= sync_last;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  // R7: a change of the filtered line follows a synchronized level that held steady
  assert_filter_steady_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(line_o) |-> ($past(sync_last, 2) == $past(sync_last)));
endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_prev_q, sda_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_f;
      sda_prev_q <= sda_f;
    end
  end

  always_comb begin
    start_o = scl_f && scl_prev_q && sda_prev_q && !sda_f;
    stop_o  = scl_f && scl_prev_q && !sda_prev_q && sda_f;
    rise_o  = scl_f && !scl_prev_q;
    fall_o  = !scl_f && scl_prev_q;
  end

  // R6: bus conditions and clock edges never coincide
  assert_events_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_o, stop_o, rise_o, fall_o}));
endmodule

// File: rtl/tw_frame_engine.sv
module tw_frame_engine
  import tw_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h2C,
  parameter logic [BYTE_W-1:0] WR_CMD = 8'hAA,
  parameter logic [BYTE_W-1:0] RD_MARK = 8'h00
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  input  logic start_i,
  input  logic stop_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic sda_pull_o,
  output logic [BYTE_W-1:0] setting_o
);
  tw_state_e st_q;
  logic [1:0] idx_q;
  logic rw_q;
  logic [BIT_CNT_W-1:0] bitcnt_q;
  logic byte_done_q;
  logic ack_ok_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] tx_q;
  logic [BYTE_W-1:0] rx_byte;

  assign rx_byte = {shreg_q[BYTE_W-2:0], sda_f};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      idx_q       <= '0;
      rw_q        <= 1'b0;
      bitcnt_q    <= '0;
      byte_done_q <= 1'b0;
      ack_ok_q    <= 1'b0;
      shreg_q     <= '0;
      tx_q        <= '0;
      sda_pull_o  <= 1'b0;
      setting_o   <= '0;
    end else if (start_i) begin
      st_q        <= ST_RX;
      idx_q       <= '0;
      bitcnt_q    <= '0;
      byte_done_q <= 1'b0;
      sda_pull_o  <= 1'b0;
    end else if (stop_i) begin
      st_q       <= ST_IDLE;
      sda_pull_o <= 1'b0;
    end else begin
      case (st_q)
        ST_RX: begin
          if (rise_i) begin
            shreg_q <= rx_byte;
            if (bitcnt_q == BIT_CNT_W'(BYTE_W - 1)) begin
              byte_done_q <= 1'b1;
              case (idx_q)
                2'd0: begin
                  ack_ok_q <= (rx_byte[BYTE_W-1:1] == SLAVE_ADDR);
                  rw_q     <= rx_byte[0];
                end
                2'd1:    ack_ok_q <= (rx_byte == WR_CMD);
                default: ack_ok_q <= 1'b1;
              endcase
            end else begin
              bitcnt_q <= bitcnt_q + 1'b1;
            end
          end else if (fall_i && byte_done_q) begin
            st_q        <= ST_ACK_OUT;
            byte_done_q <= 1'b0;
            bitcnt_q    <= '0;
            sda_pull_o  <= ack_ok_q;
          end
        end
        ST_ACK_OUT: begin
          if (fall_i) begin
            sda_pull_o <= 1'b0;
            if (!ack_ok_q) begin
              st_q <= ST_DONE;
            end else begin
              case (idx_q)
                2'd0: begin
                  idx_q <= 2'd1;
                  if (rw_q) begin
                    st_q       <= ST_TX;
                    tx_q       <= RD_MARK;
                    sda_pull_o <= !RD_MARK[BYTE_W-1];
                  end else begin
                    st_q <= ST_RX;
                  end
                end
                2'd1: begin
                  idx_q <= 2'd2;
                  st_q  <= ST_RX;
                end
                default: begin
                  setting_o <= shreg_q;
                  st_q      <= ST_DONE;
                end
              endcase
            end
          end
        end
        ST_TX: begin
          if (rise_i) begin
            if (bitcnt_q == BIT_CNT_W'(BYTE_W - 1)) begin
              byte_done_q <= 1'b1;
            end else begin
              bitcnt_q <= bitcnt_q + 1'b1;
            end
          end else if (fall_i) begin
            if (byte_done_q) begin
              st_q        <= ST_ACK_IN;
              byte_done_q <= 1'b0;
              bitcnt_q    <= '0;
              sda_pull_o  <= 1'b0;
            end else begin
              tx_q       <= {tx_q[BYTE_W-2:0], 1'b0};
              sda_pull_o <= !tx_q[BYTE_W-2];
            end
          end
        end
        ST_ACK_IN: begin
          if (rise_i) begin
            ack_ok_q <= !sda_f;
          end else if (fall_i) begin
            if (ack_ok_q && idx_q == 2'd1) begin
              idx_q      <= 2'd2;
              st_q       <= ST_TX;
              tx_q       <= setting_o;
              sda_pull_o <= !setting_o[BYTE_W-1];
            end else begin
              st_q <= ST_DONE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R6: a START restarts reception with the line released
  assert_start_restarts_R6: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (st_q == ST_RX && !sda_pull_o && bitcnt_q == '0));

  // R4: a STOP returns the engine to idle and frees the data line
  assert_stop_idles_R4: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (st_q == ST_IDLE && !sda_pull_o));

  // R10: the pull enable moves only while the filtered clock is low
  assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull_o) |-> !scl_f);

  // R9: the setting changes only at the end of the data ACK clock
  assert_commit_ack_end_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(setting_o) |-> (st_q == ST_DONE && $past(st_q) == ST_ACK_OUT && !scl_f));

  // R8: once the frame is finished the slave stays off the bus
  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DONE && $past(st_q) == ST_DONE) |-> !sda_pull_o);
endmodule

// File: rtl/tw_setting_ctrl.sv
module tw_setting_ctrl
  import tw_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN = 3,
  parameter logic [6:0] SLAVE_ADDR = 7'h2C,
  parameter logic [7:0] WR_CMD = 8'hAA,
  parameter logic [7:0] RD_MARK = 8'h00,
  parameter int DAC_W = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o,
  output logic [DAC_W-1:0] dac_code_o,
  output logic [BYTE_W-DAC_W-1:0] pin_o
);
  localparam int PIN_W = BYTE_W - DAC_W;
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] filt_lines;
  logic start_ev, stop_ev, rise_ev, fall_ev;
  logic [BYTE_W-1:0] setting;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    tw_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN(FILT_LEN),
      .RESET_LVL(1'b1)
    ) filt_i (
      .clk(clk),
      .rst(rst),
      .line_i(raw_lines[g]),
      .line_o(filt_lines[g])
    );
  end

  tw_bus_events events_i (
    .clk(clk),
    .rst(rst),
    .scl_f(filt_lines[1]),
    .sda_f(filt_lines[0]),
    .start_o(start_ev),
    .stop_o(stop_ev),
    .rise_o(rise_ev),
    .fall_o(fall_ev)
  );

  tw_frame_engine #(
    .SLAVE_ADDR(SLAVE_ADDR),
    .WR_CMD(WR_CMD),
    .RD_MARK(RD_MARK)
  ) engine_i (
    .clk(clk),
    .rst(rst),
    .scl_f(filt_lines[1]),
    .sda_f(filt_lines[0]),
    .start_i(start_ev),
    .stop_i(stop_ev),
    .rise_i(rise_ev),
    .fall_i(fall_ev),
    .sda_pull_o(sda_pull_o),
    .setting_o(setting)
  );

  assign dac_code_o = setting[BYTE_W-1:PIN_W];
  assign pin_o      = setting[PIN_W-1:0];

  // R1: outputs leave reset at zero with the line released
  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (setting == '0 && !sda_pull_o));
endmodule

// File: tb/tw_setting_ctrl_tb_top.sv
module tw_setting_ctrl_tb_top;
  localparam int HALF = 20;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic [4:0] dac_code;
  logic [2:0] pins;
  logic sda_bus;
  logic done = 1'b0;
  logic prev_pull = 1'b0;
  int checks = 0;
  int errors = 0;
  int pull_bad = 0;
  logic [7:0] cur_reg = 8'h00;

  assign sda_bus = sda_m & ~sda_pull;

  always #10 clk = ~clk;

  tw_setting_ctrl dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .dac_code_o(dac_code), .pin_o(pins)
  );

  // R10 monitor: pull enable must not move while the bench holds SCL high
  always @(negedge clk) begin
    if (!rst && sda_pull != prev_pull && scl_m) pull_bad++;
    prev_pull <= sda_pull;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic check_outputs(input string tag, input logic [7:0] v);
    check(tag, {3'b000, dac_code}, {3'b000, v[7:3]});
    check(tag, {5'b00000, pins}, {5'b00000, v[2:0]});
  endtask

  task automatic bus_start();
    wait_clk(Q); sda_m = 1'b1;
    wait_clk(HALF - Q); scl_m = 1'b1;
    wait_clk(HALF); sda_m = 1'b0;
    wait_clk(HALF); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wait_clk(Q); sda_m = 1'b0;
    wait_clk(HALF - Q); scl_m = 1'b1;
    wait_clk(HALF); sda_m = 1'b1;
    wait_clk(HALF);
  endtask

  // gk: 0 none, 1 short SCL pulse in the low phase, 2 short SDA pulse in the high phase
  task automatic bit_put(input logic b, input int gk);
    wait_clk(Q); sda_m = b;
    if (gk == 1) begin
      wait_clk(3); scl_m = 1'b1; wait_clk(2); scl_m = 1'b0;
      wait_clk(HALF - Q - 5);
    end else begin
      wait_clk(HALF - Q);
    end
    scl_m = 1'b1;
    if (gk == 2) begin
      wait_clk(8); sda_m = 1'b1; wait_clk(2); sda_m = 1'b0;
      wait_clk(HALF - 10);
    end else begin
      wait_clk(HALF);
    end
    scl_m = 1'b0;
  endtask

  task automatic ack_clock(output logic a);
    wait_clk(Q); sda_m = 1'b1;
    wait_clk(HALF - Q); scl_m = 1'b1;
    wait_clk(HALF / 2); a = sda_bus;
    wait_clk(HALF / 2); scl_m = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) bit_put(b[i], 0);
    ack_clock(a);
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      logic s;
      ack_clock(s);
      b[i] = s;
    end
    bit_put(mack, 0);
  endtask

  task automatic t_reset();
    check("R1 pull", {7'd0, sda_pull}, 8'h00);
    check_outputs("R1 outputs", 8'h00);
  endtask

  task automatic t_write(input logic [7:0] d);
    logic a0, a1, a2;
    bus_start();
    wr_byte(8'h58, a0); wr_byte(8'hAA, a1); wr_byte(d, a2);
    bus_stop();
    check("R2 addr ack", {7'd0, a0}, 8'h00);
    check("R2 cmd ack", {7'd0, a1}, 8'h00);
    check("R2 data ack", {7'd0, a2}, 8'h00);
    check_outputs("R2 outputs", d);
    cur_reg = d;
  endtask

  task automatic t_read(input string tag);
    logic a0;
    logic [7:0] m, v;
    bus_start();
    wr_byte(8'h59, a0); rd_byte(1'b0, m); rd_byte(1'b0, v);
    bus_stop();
    check({tag, " addr ack"}, {7'd0, a0}, 8'h00);
    check({tag, " marker"}, m, 8'h00);
    check({tag, " value"}, v, cur_reg);
  endtask

  task automatic t_bad_addr(input logic [7:0] ab);
    logic a0, a1, a2;
    bus_start();
    wr_byte(ab, a0); wr_byte(8'hAA, a1); wr_byte(8'h3C, a2);
    bus_stop();
    check("R4 addr nack", {7'd0, a0}, 8'h01);
    check("R4 later bytes quiet", {6'd0, a1, a2}, 8'h03);
    check_outputs("R4 unchanged", cur_reg);
  endtask

  task automatic t_bad_cmd();
    logic a0, a1, a2;
    bus_start();
    wr_byte(8'h58, a0); wr_byte(8'hAB, a1); wr_byte(8'h11, a2);
    bus_stop();
    check("R5 addr ack", {7'd0, a0}, 8'h00);
    check("R5 cmd nack", {7'd0, a1}, 8'h01);
    check("R5 data nack", {7'd0, a2}, 8'h01);
    check_outputs("R5 unchanged", cur_reg);
  endtask

  task automatic t_abort();
    logic a0, a1;
    bus_start();
    wr_byte(8'h58, a0); wr_byte(8'hAA, a1);
    for (int i = 0; i < 4; i++) bit_put(1'b1, 0);
    bus_start();
    check_outputs("R6 unchanged after abort", cur_reg);
    begin
      logic b0;
      logic [7:0] m, v;
      wr_byte(8'h59, b0); rd_byte(1'b0, m); rd_byte(1'b0, v);
      bus_stop();
      check("R6 restart addr ack", {7'd0, b0}, 8'h00);
      check("R6 restart value", v, cur_reg);
    end
  endtask

  task automatic t_glitch();
    logic a0, a1, a2;
    logic [7:0] d = 8'h96;
    bus_start();
    wr_byte(8'h58, a0); wr_byte(8'hAA, a1);
    for (int i = 7; i >= 0; i--) begin
      int gk = 0;
      if (i == 6) gk = 1;
      if (i == 5) gk = 2;
      if (i == 0) gk = 1;
      bit_put(d[i], gk);
    end
    ack_clock(a2);
    bus_stop();
    check("R7 data ack", {7'd0, a2}, 8'h00);
    check_outputs("R7 glitch-free value", d);
    cur_reg = d;
  endtask

  task automatic t_master_nack();
    logic a0;
    logic [7:0] m, v;
    bus_start();
    wr_byte(8'h59, a0); rd_byte(1'b1, m); rd_byte(1'b1, v);
    bus_stop();
    check("R8 marker", m, 8'h00);
    check("R8 no value sent", v, 8'hFF);
  endtask

  task automatic t_commit_timing();
    logic a0, a1, a2;
    logic [7:0] d = 8'h4B;
    bus_start();
    wr_byte(8'h58, a0); wr_byte(8'hAA, a1);
    for (int i = 7; i >= 0; i--) bit_put(d[i], 0);
    wait_clk(Q); sda_m = 1'b1;
    wait_clk(HALF - Q); scl_m = 1'b1;
    wait_clk(HALF / 2); a2 = sda_bus;
    check_outputs("R9 old during ACK", cur_reg);
    wait_clk(HALF / 2); scl_m = 1'b0;
    wait_clk(Q);
    check_outputs("R9 new after ACK", d);
    check("R9 data ack", {7'd0, a2}, 8'h00);
    cur_reg = d;
    bus_stop();
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    t_reset();
    t_write(8'hA5);
    t_read("R3");
    t_write(8'hF8);
    t_write(8'h07);
    t_read("R3 second");
    t_bad_addr(8'h5A);
    t_bad_addr(8'h68);
    t_bad_cmd();
    t_abort();
    t_glitch();
    t_master_nack();
    t_commit_timing();
    t_read("R3 final");
    check("R10 pull moved with SCL high", pull_bad[7:0], 8'h00);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule